// File: doc/BRIEF.md
# PHY Trim Parameter Sequencer

This block loads a short table of analog trim settings into a PHY through its narrow test port. The port has a 32-bit command word, written by the block, and a 32-bit readback word that the block samples. One access happens per clock: either a command write (`cmd_wr`) or a readback sample (`rd_strobe`). The PHY answers a sample in the same cycle, and the port has no back-pressure, so the block never stalls. Each table entry names a PHY register, a bit range inside that 8-bit register, and a value. For each entry the block reads the register, merges the value into the bit range, writes the result back with a strobed write, and then reads the register once more as a dummy read.

Software or a boot controller pulses `start` with the table on the parameter ports and the entry count on `entry_cnt`. Both must stay stable until `done` is seen. Every command update is followed by two discarded readback samples. A write is three command updates with identical data and address, and the enable bit is set only on the middle update. A legacy input skips the whole procedure. Each entry takes 17 clocks.

Top module: `phy_trim_seq`

## Requirements
- R1: A command word has the 8-bit data field in bits 13:6, the 5-bit PHY register address in bits 5:1, the write enable in bit 0, and zeros in bits 31:14.
- R2: Every command write is followed by exactly two readback samples, which are discarded. A command write and a sample never happen in the same cycle.
- R3: A register read drives the address with data field 1 and enable 0, then takes a third sample after the two discarded ones, and keeps readback bits 7:0 as the old register contents. All other readback bits are ignored.
- R4: A write issues three command updates with the same data and address. Bit 0 is 0, then 1, then 0.
- R5: The written data is (old & ~mask) | ((value << lsb) & mask), where mask covers bits msb down to lsb. Value bits outside the field have no effect.
- R6: After each write, the block issues a dummy read of the same register (data field 1, enable 0) followed by three samples, and the last of these is ignored.
- R7: Entries are applied in table order for a runtime count of 1 to 7 (entry i uses slice i of each table port). A count of 0 makes no accesses and gives `done` on the next cycle.
- R8: When `legacy` is high at start, the block makes no accesses and raises `done` on the cycle after `start`.
- R9: A count above 7 raises `err` for one cycle on the cycle after `start`. It makes no accesses and gives no `done`.
- R10: A `start` pulse while `busy` is high is ignored, and the running sequence continues unchanged.
- R11: `busy` is high for every access cycle of a run. `done` is a one-cycle pulse on the cycle after the last access, and `done` and `err` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted only while idle |
| legacy | input | 1 | Skip programming, finish at once |
| entry_cnt | input | 4 | Number of table entries to apply |
| tbl_addr | input | 35 | Packed PHY register numbers, 5 bits per entry |
| tbl_msb | input | 21 | Packed field top bit, 3 bits per entry |
| tbl_lsb | input | 21 | Packed field bottom bit, 3 bits per entry |
| tbl_val | input | 56 | Packed field values, 8 bits per entry |
| cmd_wr | output | 1 | Command word write this cycle |
| cmd_word | output | 32 | Command word, zero when cmd_wr is low |
| rd_strobe | output | 1 | Readback sample this cycle |
| rd_word | input | 32 | Readback word, valid in the strobe cycle |
| busy | output | 1 | Sequence running |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for an oversized count |

## Verification
The bench preloads the PHY model with non-zero registers and puts junk in the upper readback bits. A design that overwrote the register instead of merging, or that took the wrong readback bits, would write wrong data. One table programs two fields of the same register in sequence, so a design that reordered entries or reused a stale old value would leave that register wrong. Values wider than their field check the mask, and a mid-run `start` checks that a busy design does not restart. Legacy mode, a count of 0 and a count of 8 check that no access leaks out and that `done` and `err` each fire alone.

// File: rtl/trim_pkg.sv
package trim_pkg;
  // steps of one entry, one port access per step
  localparam int LAST_STEP = 16;
  localparam int STEP_W    = 5;

  typedef enum logic {S_IDLE, S_RUN} seq_state_e;

  typedef struct packed {
    logic is_cmd;     // command write, else readback sample
    logic use_merge;  // data field = merged value, else 1
    logic wr_en;      // enable bit of the command word
    logic capture;    // keep readback as old register contents
  } step_ctl_t;
endpackage

// File: rtl/trim_step_decode.sv
module trim_step_decode
  import trim_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  output step_ctl_t         ctl
);
  always_comb begin
    ctl = '0;
    unique case (step)
      5'd0:  ctl.is_cmd = 1'b1;                       // read request
      5'd3:  ctl.capture = 1'b1;                      // old value sample
      5'd4:  begin ctl.is_cmd = 1'b1; ctl.use_merge = 1'b1; end
      5'd7:  begin ctl.is_cmd = 1'b1; ctl.use_merge = 1'b1; ctl.wr_en = 1'b1; end
      5'd10: begin ctl.is_cmd = 1'b1; ctl.use_merge = 1'b1; end
      5'd13: ctl.is_cmd = 1'b1;                       // dummy read
      default: ctl = '0;                              // readback samples
    endcase
  end
endmodule

// File: rtl/trim_field_merge.sv
module trim_field_merge #(
  parameter int DATA_W = 8,
  parameter int POS_W  = 3
) (
  input  logic [DATA_W-1:0] old_val,
  input  logic [POS_W-1:0]  msb,
  input  logic [POS_W-1:0]  lsb,
  input  logic [DATA_W-1:0] new_val,
  output logic [DATA_W-1:0] merged
);
  logic [DATA_W-1:0] mask;

  always_comb begin
    for (int b = 0; b < DATA_W; b++)
      mask[b] = (b >= int'(lsb)) && (b <= int'(msb));
    merged = (old_val & ~mask) | ((new_val << lsb) & mask);
  end
endmodule

// File: rtl/trim_entry_mux.sv
module trim_entry_mux #(
  parameter int MAX_ENTRIES = 7,
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 8,
  parameter int POS_W       = 3,
  localparam int IDX_W      = $clog2(MAX_ENTRIES)
) (
  input  logic [IDX_W-1:0]              idx,
  input  logic [MAX_ENTRIES*ADDR_W-1:0] tbl_addr,
  input  logic [MAX_ENTRIES*POS_W-1:0]  tbl_msb,
  input  logic [MAX_ENTRIES*POS_W-1:0]  tbl_lsb,
  input  logic [MAX_ENTRIES*DATA_W-1:0] tbl_val,
  output logic [ADDR_W-1:0]             addr,
  output logic [POS_W-1:0]              msb,
  output logic [POS_W-1:0]              lsb,
  output logic [DATA_W-1:0]             val
);
  logic [ADDR_W-1:0] a_arr [MAX_ENTRIES];
  logic [POS_W-1:0]  m_arr [MAX_ENTRIES];
  logic [POS_W-1:0]  l_arr [MAX_ENTRIES];
  logic [DATA_W-1:0] v_arr [MAX_ENTRIES];

  for (genvar g = 0; g < MAX_ENTRIES; g++) begin : g_unpack
    assign a_arr[g] = tbl_addr[g*ADDR_W +: ADDR_W];
    assign m_arr[g] = tbl_msb[g*POS_W +: POS_W];
    assign l_arr[g] = tbl_lsb[g*POS_W +: POS_W];
    assign v_arr[g] = tbl_val[g*DATA_W +: DATA_W];
  end

  always_comb begin
    addr = '0; msb = '0; lsb = '0; val = '0;
    for (int i = 0; i < MAX_ENTRIES; i++)
      if (int'(idx) == i) begin
        addr = a_arr[i]; msb = m_arr[i]; lsb = l_arr[i]; val = v_arr[i];
      end
  end
endmodule

// File: rtl/phy_trim_seq.sv
module phy_trim_seq
  import trim_pkg::*;
#(
  parameter int MAX_ENTRIES = 7,
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 8,
  parameter int POS_W       = 3,
  parameter int CNT_W       = 4,
  parameter int CMD_W       = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          legacy,
  input  logic [CNT_W-1:0]              entry_cnt,
  input  logic [MAX_ENTRIES*ADDR_W-1:0] tbl_addr,
  input  logic [MAX_ENTRIES*POS_W-1:0]  tbl_msb,
  input  logic [MAX_ENTRIES*POS_W-1:0]  tbl_lsb,
  input  logic [MAX_ENTRIES*DATA_W-1:0] tbl_val,
  output logic                          cmd_wr,
  output logic [CMD_W-1:0]              cmd_word,
  output logic                          rd_strobe,
  input  logic [CMD_W-1:0]              rd_word,
  output logic                          busy,
  output logic                          done,
  output logic                          err
);
  localparam int IDX_W    = $clog2(MAX_ENTRIES);
  localparam int ADDR_LSB = 1;
  localparam int DATA_LSB = ADDR_LSB + ADDR_W;

  seq_state_e        state_q;
  logic [STEP_W-1:0] step_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] old_q;
  logic              done_q, err_q;

  step_ctl_t         ctl;
  logic [ADDR_W-1:0] e_addr;
  logic [POS_W-1:0]  e_msb, e_lsb;
  logic [DATA_W-1:0] e_val, merged;
  logic              last_entry;

  trim_step_decode i_dec (.step(step_q), .ctl(ctl));

  trim_entry_mux #(
    .MAX_ENTRIES(MAX_ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .POS_W(POS_W)
  ) i_mux (
    .idx(idx_q), .tbl_addr(tbl_addr), .tbl_msb(tbl_msb), .tbl_lsb(tbl_lsb),
    .tbl_val(tbl_val), .addr(e_addr), .msb(e_msb), .lsb(e_lsb), .val(e_val)
  );

  trim_field_merge #(.DATA_W(DATA_W), .POS_W(POS_W)) i_merge (
    .old_val(old_q), .msb(e_msb), .lsb(e_lsb), .new_val(e_val), .merged(merged)
  );

  assign last_entry = (CNT_W'(idx_q) + CNT_W'(1)) == cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      old_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (start) begin
            if (legacy || entry_cnt == '0) begin
              done_q <= 1'b1;
            end else if (int'(entry_cnt) > MAX_ENTRIES) begin
              err_q <= 1'b1;
            end else begin
              state_q <= S_RUN;
              step_q  <= '0;
              idx_q   <= '0;
              cnt_q   <= entry_cnt;
            end
          end
        end
        S_RUN: begin
          if (ctl.capture) old_q <= rd_word[DATA_W-1:0];
          if (int'(step_q) == LAST_STEP) begin
            step_q <= '0;
            if (last_entry) begin
              state_q <= S_IDLE;
              done_q  <= 1'b1;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
            end
          end else begin
            step_q <= step_q + STEP_W'(1);
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_word  = '0;
    cmd_wr    = 1'b0;
    rd_strobe = 1'b0;
    if (state_q == S_RUN) begin
      cmd_wr    = ctl.is_cmd;
      rd_strobe = !ctl.is_cmd;
      if (ctl.is_cmd) begin
        cmd_word[DATA_LSB +: DATA_W] = ctl.use_merge ? merged : DATA_W'(1);
        cmd_word[ADDR_LSB +: ADDR_W] = e_addr;
        cmd_word[0]                  = ctl.wr_en;
      end
    end
  end

  assign busy = (state_q == S_RUN);
  assign done = done_q;
  assign err  = err_q;
endmodule

// File: rtl/trim_seq_chk.sv
module trim_seq_chk #(
  parameter int CMD_W  = 32,
  parameter int TOP_LSB = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_wr,
  input logic [CMD_W-1:0] cmd_word,
  input logic             rd_strobe,
  input logic             busy,
  input logic             done,
  input logic             err
);
  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> cmd_word[CMD_W-1:TOP_LSB] == '0);

  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_wr && rd_strobe));

  assert_two_samples_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> rd_strobe ##1 rd_strobe);

  assert_enable_middle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_word[0]) |-> ($past(cmd_wr, 3) && !$past(cmd_word[0], 3)
      && $past(cmd_word[CMD_W-1:1], 3) == cmd_word[CMD_W-1:1]));

  assert_enable_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_word[0]) |-> ##3 (cmd_wr && !cmd_word[0]));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cmd_wr && !rd_strobe));

  assert_flags_apart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err}));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);
endmodule

bind phy_trim_seq trim_seq_chk #(.CMD_W(CMD_W), .TOP_LSB(1 + ADDR_W + DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
  .rd_strobe(rd_strobe), .busy(busy), .done(done), .err(err)
);

// File: tb/test_phy_trim_seq.sv
`timescale 1ns/1ps
module test_phy_trim_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        legacy = 1'b0;
  logic [3:0]  entry_cnt = '0;
  logic [34:0] tbl_addr = '0;
  logic [20:0] tbl_msb = '0;
  logic [20:0] tbl_lsb = '0;
  logic [55:0] tbl_val = '0;
  logic        cmd_wr, rd_strobe, busy, done, err;
  logic [31:0] cmd_word, rd_word;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  phy_trim_seq i_phy_trim_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .legacy(legacy), .entry_cnt(entry_cnt),
    .tbl_addr(tbl_addr), .tbl_msb(tbl_msb), .tbl_lsb(tbl_lsb), .tbl_val(tbl_val),
    .cmd_wr(cmd_wr), .cmd_word(cmd_word), .rd_strobe(rd_strobe), .rd_word(rd_word),
    .busy(busy), .done(done), .err(err)
  );

  // PHY test-port model
  logic [7:0] phy_mem [32];
  logic [4:0] phy_sel = '0;
  assign rd_word = {24'hC3A55A, phy_mem[phy_sel]};
  always @(posedge clk) if (cmd_wr) begin
    phy_sel <= cmd_word[5:1];
    if (cmd_word[0]) phy_mem[cmd_word[5:1]] <= cmd_word[13:6];
  end

  // reference model
  int mdl [32];
  typedef struct { bit c; logic [31:0] w; string req; } ev_t;
  ev_t q [$];

  function automatic logic [31:0] cw(int a, int d, int we);
    return 32'((d & 8'hFF) << 6) | 32'((a & 31) << 1) | 32'(we & 1);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_entry(int i, int a, int m, int l, int v);
    tbl_addr[i*5 +: 5] = 5'(a);
    tbl_msb[i*3 +: 3]  = 3'(m);
    tbl_lsb[i*3 +: 3]  = 3'(l);
    tbl_val[i*8 +: 8]  = 8'(v);
  endtask

  task automatic push(bit c, logic [31:0] w, string req);
    ev_t e; e.c = c; e.w = w; e.req = req; q.push_back(e);
  endtask

  task automatic build(int n);
    for (int e = 0; e < n; e++) begin
      int a, m, l, v, mask, nv;
      a = int'(tbl_addr[e*5 +: 5]); m = int'(tbl_msb[e*3 +: 3]);
      l = int'(tbl_lsb[e*3 +: 3]);  v = int'(tbl_val[e*8 +: 8]);
      mask = 0;
      for (int b = l; b <= m; b++) mask |= (1 << b);
      nv = (mdl[a] & ~mask & 255) | ((v << l) & mask);
      push(1, cw(a, 1, 0), "R3"); push(0, 0, "R2"); push(0, 0, "R2"); push(0, 0, "R3");
      push(1, cw(a, nv, 0), "R5"); push(0, 0, "R2"); push(0, 0, "R2");
      push(1, cw(a, nv, 1), "R4"); push(0, 0, "R2"); push(0, 0, "R2");
      push(1, cw(a, nv, 0), "R4"); push(0, 0, "R2"); push(0, 0, "R2");
      push(1, cw(a, 1, 0), "R6"); push(0, 0, "R6"); push(0, 0, "R6"); push(0, 0, "R6");
      mdl[a] = nv;
    end
  endtask

  // start at a negedge; outputs compared at every following negedge
  task automatic run(int n, bit leg, int poke_at, string req);
    int k;
    legacy = leg; entry_cnt = 4'(n);
    if (!leg && n >= 1 && n <= 7) build(n);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    k = 0;
    while (q.size() > 0) begin
      ev_t e;
      e = q.pop_front();
      if (k == poke_at) start = 1'b1; else start = 1'b0;
      if (e.c) check(cmd_wr && !rd_strobe && cmd_word == e.w, e.req, "command word",
                     int'(cmd_word), int'(e.w));
      else check(rd_strobe && !cmd_wr, e.req, "readback sample",
                 int'({cmd_wr, rd_strobe}), 1);
      check(busy && !done, "R11", "busy during run", int'({busy, done}), 2);
      k++;
      @(negedge clk);
    end
    start = 1'b0;
    legacy = 1'b0;
    if (n > 7 && !leg) begin
      check(err && !done && !busy, "R9", "err pulse", int'({err, done, busy}), 4);
    end else begin
      check(done && !err && !busy, req, "done after last access", int'({done, err, busy}), 4);
    end
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      check(!done && !err && !busy && !cmd_wr && !rd_strobe, req, "quiet after end",
            int'({done, err, busy, cmd_wr, rd_strobe}), 0);
      @(negedge clk);
    end
  endtask

  task automatic check_mem(string req);
    bit ok = 1;
    int bad = 0;
    for (int r = 0; r < 32; r++)
      if (int'(phy_mem[r]) != mdl[r]) begin ok = 0; bad = r; end
    check(ok, req, "PHY register contents", int'(phy_mem[bad]), mdl[bad]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int r = 0; r < 32; r++) begin
      phy_mem[r] = 8'((r * 37 + 8'h5C) & 255);
      mdl[r] = (r * 37 + 8'h5C) & 255;
    end
    repeat (3) @(negedge clk);
    check(!busy && !done && !err && !cmd_wr && !rd_strobe, "R11", "reset state",
          int'({busy, done, err, cmd_wr, rd_strobe}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // full seven-entry table, several fields per register width
    set_entry(0, 7, 3, 0, 10); set_entry(1, 8, 3, 0, 3);  set_entry(2, 9, 3, 0, 5);
    set_entry(3, 11, 3, 0, 9); set_entry(4, 13, 6, 5, 2); set_entry(5, 27, 2, 0, 7);
    set_entry(6, 28, 1, 0, 1);
    run(7, 0, -1, "R7");
    check_mem("R5");

    // same register twice in order, values wider than field, start poked while busy
    set_entry(0, 13, 6, 5, 8'hFF); set_entry(1, 13, 3, 0, 6); set_entry(2, 26, 7, 4, 5);
    run(3, 0, 20, "R10");
    check_mem("R7");

    // single entry, top bit field
    set_entry(0, 31, 7, 7, 0);
    run(1, 0, -1, "R6");
    check_mem("R5");

    // legacy with a valid table: no accesses
    run(3, 1, -1, "R8");
    check_mem("R8");

    // zero count
    run(0, 0, -1, "R7");

    // oversized count
    run(8, 0, -1, "R9");
    run(15, 0, -1, "R9");
    check_mem("R9");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule